// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block serializes one byte at a time onto an asynchronous serial line that rests high. Software places a byte into a single-entry holding buffer through a valid/ready write. While transmission is enabled, the byte moves into a shift register and goes out as a start bit, eight data bits least significant first, an optional ninth bit, and one or two stop bits. A 2-bit format code picks one of four frame shapes. A single polarity bit does two jobs: it selects the parity sense when the frame carries parity, and it is the constant ninth bit when the frame carries nine data bits.

Bit timing comes from a 12-bit divider. Software writes it as a 4-bit upper field and an 8-bit lower field. The block shows two status levels: the buffer is empty, and the line has finished a frame with nothing waiting. Each status has its own interrupt enable, and a global enable gates both onto one interrupt output. When a new byte is already waiting at the end of a stop bit, the next start bit follows at once.

Top module: `cfg_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` and `wr_ready` are 1, and `tx_done` and `irq` are 0. `txd` stays 1 whenever no frame is being sent.
- R2: Format code 2'b00 sends 10 bits: a start bit of 0, data bits 0 to 7 in order, then one stop bit of 1.
- R3: Format code 2'b01 sends 11 bits: start, 8 data bits, then two stop bits of 1.
- R4: Format code 2'b10 sends start, 8 data bits, a parity bit, then one stop bit. With `par_sel`=1 the parity is even (the bit equals the XOR of the data). With `par_sel`=0 it is odd.
- R5: Format code 2'b11 sends start, 8 data bits, a ninth bit equal to `par_sel`, then one stop bit.
- R6: Every bit lasts exactly P+1 clocks, where P = {`presc_hi`,`presc_lo`}. When P=0, each bit lasts one clock.
- R7: A write is accepted only at a clock edge with `wr_valid`=1 and `wr_ready`=1. A write made while the buffer is full is dropped. `buf_empty` goes to 0 after an accepted write. It returns to 1 in the cycle the start bit begins, which is one clock after the write when the line is idle and enabled.
- R8: `tx_done` rises at the end of the last stop bit if no byte is waiting. It is cleared when a frame starts. When a byte is waiting, its start bit follows the previous stop bit with no idle clock, and `tx_done` stays 0.
- R9: While `tx_en`=0, no frame starts and a buffered byte stays held. Clearing `tx_en` in mid-frame lets the current frame finish.
- R10: `irq` = `ie_global` AND ((`ie_empty` AND `buf_empty`) OR (`ie_done` AND `tx_done`)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| frame_sel | input | 2 | Frame format code |
| par_sel | input | 1 | Parity sense or constant ninth bit |
| presc_hi | input | 4 | Divider bits 11:8 |
| presc_lo | input | 8 | Divider bits 7:0 |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Buffer can accept a write |
| ie_empty | input | 1 | Interrupt enable for buffer empty |
| ie_done | input | 1 | Interrupt enable for frame complete |
| ie_global | input | 1 | Global interrupt gate |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | Frame finished with no byte waiting |
| irq | output | 1 | Gated interrupt request |

## Verification
On every cycle, the assertions check that the line rests high when idle and goes low the clock after a frame starts. They also check that the line holds steady between bit ticks, that no frame starts while the transmitter is disabled, that starting a frame empties the buffer and clears `tx_done`, and that the global gate keeps `irq` low. Only the bench scenarios can show the bit order of each format, the parity value, the exact period for a given divider, the dropped write to a full buffer, the seamless back-to-back frames, and a frame that completes after the enable is cleared.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int FRAME_W = 11;
  localparam int BITS_W  = 4;

  typedef enum logic [1:0] {
    FMT_8N1 = 2'b00,
    FMT_8N2 = 2'b01,
    FMT_8P1 = 2'b10,
    FMT_9N1 = 2'b11
  } fmt_e;

  // Frame laid out LSB first: start, data, bit nine, stop(s); unused tail is 1.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d,
                                                     input fmt_e f,
                                                     input logic pol);
    logic b9;
    case (f)
      FMT_8P1: b9 = pol ? (^d) : ~(^d);
      FMT_9N1: b9 = pol;
      default: b9 = 1'b1;
    endcase
    return {1'b1, b9, d, 1'b0};
  endfunction

  function automatic logic [BITS_W-1:0] frame_bits(input fmt_e f);
    return (f == FMT_8N1) ? BITS_W'(10) : BITS_W'(11);
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt;

  assign tick = run && (cnt >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_valid && !full) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  input  logic [BITS_W-1:0]  nbits,
  input  logic               tick,
  output logic               txd,
  output logic               busy,
  output logic               last_tick
);
  logic [FRAME_W-1:0] shreg;
  logic [BITS_W-1:0]  left;

  assign last_tick = tick && (left == BITS_W'(1));
  assign txd       = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= word;
      left  <= nbits;
      busy  <= 1'b1;
    end else if (tick) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - 1'b1;
      if (left == BITS_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
  import uart_tx_pkg::*;
#(
  parameter int HI_W = 4,
  parameter int LO_W = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en,
  input  logic [1:0]      frame_sel,
  input  logic            par_sel,
  input  logic [HI_W-1:0] presc_hi,
  input  logic [LO_W-1:0] presc_lo,
  input  logic            wr_valid,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_ready,
  input  logic            ie_empty,
  input  logic            ie_done,
  input  logic            ie_global,
  output logic            txd,
  output logic            buf_empty,
  output logic            tx_done,
  output logic            irq
);
  localparam int PW = HI_W + LO_W;

  // Named internal events, observed by the bound checker.
  logic          buf_full;
  logic [DW-1:0] buf_data;
  logic          busy;
  logic          bit_tick;
  logic          last_tick;
  logic          load_evt;
  logic [PW-1:0] period;

  assign period   = {presc_hi, presc_lo};
  assign load_evt = buf_full && tx_en && (!busy || last_tick);

  uart_tx_buffer #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(load_evt), .full(buf_full), .data(buf_data)
  );

  uart_baud_gen #(.PW(PW)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .period(period), .tick(bit_tick)
  );

  uart_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt),
    .word(build_frame(buf_data[7:0], fmt_e'(frame_sel), par_sel)),
    .nbits(frame_bits(fmt_e'(frame_sel))),
    .tick(bit_tick), .txd(txd), .busy(busy), .last_tick(last_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_done <= 1'b0;
    else if (load_evt)  tx_done <= 1'b0;
    else if (last_tick) tx_done <= 1'b1;
  end

  assign buf_empty = !buf_full;
  assign wr_ready  = !buf_full;
  assign irq       = ie_global && ((ie_empty && buf_empty) || (ie_done && tx_done));
endmodule

// File: rtl/uart_tx_checks.sv
module uart_tx_checks (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic ie_global,
  input logic irq,
  input logic txd,
  input logic busy,
  input logic load_evt,
  input logic bit_tick,
  input logic tx_done,
  input logic buf_empty
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !txd);

  assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick && !load_evt) |=> $stable(txd));

  assert_buffer_freed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> buf_empty);

  assert_done_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !tx_done);

  assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !load_evt);

  assert_global_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_global |-> !irq);
endmodule

bind cfg_uart_tx uart_tx_checks u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ie_global(ie_global), .irq(irq),
  .txd(txd), .busy(busy), .load_evt(load_evt), .bit_tick(bit_tick),
  .tx_done(tx_done), .buf_empty(buf_empty)
);

// File: tb/sim_cfg_uart_tx.sv
module sim_cfg_uart_tx;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  fr;
    logic        pol;
    logic [11:0] presc;
    logic [7:0]  d;
    logic [3:0]  nb;
    logic [10:0] exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{2'b00, 1'b0, 12'd0,     8'hA5, 4'd10, {2'b11, 8'hA5, 1'b0}},  // R2
    '{2'b01, 1'b1, 12'd2,     8'h3C, 4'd11, {2'b11, 8'h3C, 1'b0}},  // R3
    '{2'b10, 1'b1, 12'd1,     8'h07, 4'd11, {1'b1, 1'b1, 8'h07, 1'b0}}, // R4 even
    '{2'b10, 1'b0, 12'd3,     8'h07, 4'd11, {1'b1, 1'b0, 8'h07, 1'b0}}, // R4 odd
    '{2'b10, 1'b1, 12'd0,     8'h81, 4'd11, {1'b1, 1'b0, 8'h81, 1'b0}}, // R4 even
    '{2'b11, 1'b1, 12'd5,     8'h00, 4'd11, {1'b1, 1'b1, 8'h00, 1'b0}}, // R5
    '{2'b11, 1'b0, 12'd0,     8'hFF, 4'd11, {1'b1, 1'b0, 8'hFF, 1'b0}}, // R5
    '{2'b10, 1'b0, 12'h101,   8'h00, 4'd11, {1'b1, 1'b1, 8'h00, 1'b0}}  // R4 odd, R6 high field
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic [1:0] frame_sel = 2'b00;
  logic par_sel = 1'b0;
  logic [3:0] presc_hi = '0;
  logic [7:0] presc_lo = '0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic ie_empty = 1'b0, ie_done = 1'b0, ie_global = 1'b0;
  logic wr_ready, txd, buf_empty, tx_done, irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_uart_tx u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_sel(frame_sel),
    .par_sel(par_sel), .presc_hi(presc_hi), .presc_lo(presc_lo),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .ie_empty(ie_empty), .ie_done(ie_done), .ie_global(ie_global),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic set_cfg(input logic [1:0] fr, input logic pol, input logic [11:0] p);
    frame_sel = fr;
    par_sel   = pol;
    presc_hi  = p[11:8];
    presc_lo  = p[7:0];
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Called at the first negedge of the start bit.
  task automatic run_frame(input logic [10:0] exp, input int nb, input int p, input string req);
    for (int k = 0; k < nb; k++) begin
      if (k > 0) repeat (p + 1) @(negedge clk);
      chk(txd == exp[k], req, txd, exp[k]);
    end
    repeat (p) @(negedge clk);
    chk(tx_done == 1'b0, "R8 done before stop end", tx_done, 0);
    @(negedge clk);
    chk(tx_done == 1'b1 && txd == 1'b1, "R8 done after stop", tx_done, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(txd == 1'b1 && buf_empty && wr_ready, "R1 reset line/buffer", txd, 1);
    chk(tx_done == 1'b0 && irq == 1'b0, "R1 reset status", tx_done, 0);
    rst_n = 1'b1;
    tx_en = 1'b1;
    @(negedge clk);

    // Table of frames: format, polarity, divider, data, expected bits.
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VEC[v].fr, VEC[v].pol, VEC[v].presc);
      write_byte(VEC[v].d);
      chk(buf_empty == 1'b0 && txd == 1'b1, "R7 accepted write", buf_empty, 0);
      @(negedge clk);
      chk(txd == 1'b0 && buf_empty == 1'b1, "R7 load one clock later", txd, 0);
      run_frame(VEC[v].exp, int'(VEC[v].nb), int'(VEC[v].presc), "R6 frame bit");
    end

    // R9: disabled transmitter holds a buffered byte; R7: write to full buffer dropped
    tx_en = 1'b0;
    set_cfg(2'b00, 1'b0, 12'd0);
    write_byte(8'h55);
    chk(buf_empty == 1'b0 && wr_ready == 1'b0, "R7 buffer full", wr_ready, 0);
    repeat (30) @(negedge clk);
    chk(txd == 1'b1 && buf_empty == 1'b0, "R9 no start while disabled", txd, 1);
    write_byte(8'hAA);
    tx_en = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R9 start after enable", txd, 0);
    run_frame({2'b11, 8'h55, 1'b0}, 10, 0, "R7 dropped write not sent");

    // R9: clearing enable mid-frame lets frame finish
    set_cfg(2'b00, 1'b0, 12'd3);
    write_byte(8'h33);
    @(negedge clk);
    chk(txd == 1'b0, "R9 frame start", txd, 0);
    repeat (8) @(negedge clk);
    tx_en = 1'b0;
    write_byte(8'hCC);
    repeat (29) @(negedge clk);
    chk(tx_done == 1'b0 && txd == 1'b1, "R9 stop bit in progress", tx_done, 0);
    @(negedge clk);
    chk(tx_done == 1'b1, "R9 frame finished after disable", tx_done, 1);
    repeat (20) @(negedge clk);
    chk(txd == 1'b1 && buf_empty == 1'b0, "R9 no new frame", txd, 1);
    tx_en = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0 && buf_empty == 1'b1, "R9 resumes", txd, 0);
    run_frame({2'b11, 8'hCC, 1'b0}, 10, 3, "R9 held byte");

    // R8: back-to-back frames with no gap
    set_cfg(2'b00, 1'b0, 12'd1);
    write_byte(8'h0F);
    @(negedge clk);
    chk(txd == 1'b0, "R8 first start", txd, 0);
    write_byte(8'hF0);
    repeat (17) @(negedge clk);
    chk(txd == 1'b1 && tx_done == 1'b0, "R8 stop of first", txd, 1);
    @(negedge clk);
    chk(txd == 1'b0 && tx_done == 1'b0, "R8 seamless second start", txd, 0);
    run_frame({2'b11, 8'hF0, 1'b0}, 10, 1, "R8 second frame");

    // R10: interrupt gating (idle, buffer empty, tx_done=1)
    ie_global = 1'b0; ie_empty = 1'b1; ie_done = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R10 global gate off", irq, 0);
    ie_global = 1'b1; ie_empty = 1'b0; ie_done = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R10 both masked", irq, 0);
    ie_done = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R10 done source", irq, 1);
    ie_done = 1'b0; ie_empty = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R10 empty source", irq, 1);
    tx_en = 1'b0;
    write_byte(8'h11);
    chk(irq == 1'b0, "R10 empty source cleared by write", irq, 0);
    ie_done = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R10 done still set", irq, 1);

    summary();
  end
endmodule